// File: doc/BRIEF.md
# Shared Conversion-Status and Read-Clock Output

This block is the output side of a converter's serial port, where one output pin does two jobs. While chip select is released, the pin reports conversion status. A start strobe launches a conversion of fixed length. The pin is low while that conversion runs and returns high when it ends. While chip select is held, the same pin becomes a source-synchronous read clock. Four data lanes send the last completed result in double-data-rate fashion, and the lanes are enabled only during that time.

The readout path does not depend on the converter. A word can be read while a new conversion is running. The captured word stays as it was even if the conversion finishes during the transfer. The analog converter is replaced by a counter model. Its conversion length is a parameter, and it loads `sample_in` into the result register at end of conversion. Chip select always has priority over status on the shared pin. When chip select is released during a conversion, the pin shows the low status until that conversion ends.

Top module: `ssc_status_clock_pin`

## Requirements
- R1: After synchronous reset, `status_clk` is 1, `sdo_oe` is 0 and `sdo_data` is 0.
- R2: A `conv_start` sampled high at a clock edge while idle makes `status_clk` low from that edge for exactly CONV_CYCLES cycles, then high again (chip select released). At the edge that ends the conversion, the result register loads `sample_in`.
- R3: A `conv_start` sampled while a conversion is busy is ignored. The conversion still ends CONV_CYCLES cycles after the accepted strobe.
- R4: While `sdo_oe` is 0, `status_clk` shows conversion status: low when busy, high when idle. If chip select is released during a conversion, the pin stays low until that conversion ends.
- R5: From the first edge that samples `cs_n` low, `status_clk` is the read clock. It is low for the first cycle, then changes level every cycle for W/LANES cycles in total, whatever the conversion state.
- R6: After those W/LANES cycles, `status_clk` stays high for as long as chip select remains asserted, even during a conversion.
- R7: `sdo_oe` is 1 exactly in the cycles after an edge that sampled `cs_n` low. While it is 0, `sdo_data` is 0.
- R8: Transfer cycle j (j = 0 first) carries word bits [W-1-j*LANES -: LANES], most significant nibble first. Lane l carries the lower-indexed bit plus l.
- R9: A transfer sends the result held at the edge that sampled `cs_n` low. A conversion that runs or ends during the transfer does not change the transferred word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all logic on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Start-conversion strobe |
| cs_n | input | 1 | Chip select, active low, sampled on clk |
| sample_in | input | W | Value captured by the busy model at end of conversion |
| status_clk | output | 1 | Shared pin: conversion status or read clock |
| sdo_data | output | LANES | Serial data lanes, DDR with `status_clk` |
| sdo_oe | output | 1 | Output enable for the data lanes (high-impedance when 0) |

## Verification
Two functions can fall in the same window: a running conversion, which drives status, and a read transfer, which drives the clock. The bench provokes this by asserting chip select right after a strobe, and again just before the conversion ends, so that end of conversion falls inside the transfer. A scoreboard checks the clock level and lane nibble for each transfer cycle against the word that was current when chip select was sampled. After the transfer, the pin must stay high while chip select is held. After release, it must show the low busy status until the conversion ends.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    SRC_STATUS = 1'b0,
    SRC_RDCLK  = 1'b1
  } pin_src_e;
endpackage

// File: rtl/ssc_busy_model.sv
module ssc_busy_model #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_start,
  input  logic [W-1:0] sample_in,
  output logic         busy,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      result_q <= '0;
    end else if (!busy_q) begin
      if (conv_start) begin
        busy_q <= 1'b1;
        cnt_q  <= LAST;
      end
    end else if (cnt_q == '0) begin
      busy_q   <= 1'b0;
      result_q <= sample_in;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign result = result_q;

  // R2, R3: busy period counts down one step per cycle, no restart
  assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R2: busy only begins after an accepted strobe
  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !$past(busy_q)) |-> ($past(conv_start) && cnt_q == LAST));

  // R9: result changes only at end of conversion
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (result_q != $past(result_q)) |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/ssc_ddr_readout.sv
module ssc_ddr_readout #(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic [W-1:0]     result,
  output logic             rd_clk,
  output logic [LANES-1:0] rd_data,
  output logic             rd_oe
);
  localparam int NIB = W / LANES;
  localparam int IW  = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NIB - 1);

  logic             act_q;
  logic [IW-1:0]    idx_q;
  logic [W-1:0]     word_q;
  logic             clk_q;
  logic [LANES-1:0] data_q;
  logic             oe_q;
  logic [LANES-1:0] top_res;
  logic [LANES-1:0] top_word;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign top_res[l]  = result[W-LANES+l];
    assign top_word[l] = word_q[W-LANES+l];
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      clk_q  <= 1'b1;
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (!oe_q) begin
        act_q  <= 1'b1;
        idx_q  <= IW'(1);
        word_q <= result << LANES;
        data_q <= top_res;
        clk_q  <= 1'b0;
      end else if (act_q) begin
        word_q <= word_q << LANES;
        data_q <= top_word;
        clk_q  <= idx_q[0];
        idx_q  <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) act_q <= 1'b0;
      end else begin
        clk_q <= 1'b1;
      end
    end
  end

  assign rd_clk  = clk_q;
  assign rd_data = data_q;
  assign rd_oe   = oe_q;

  // R5: transfer opens with the clock low
  assert_first_low_R5: assert property (@(posedge clk) disable iff (rst)
    (oe_q && !$past(oe_q)) |-> (!clk_q && act_q));

  // R5: clock changes level every cycle of an active transfer
  assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q && $past(act_q)) |-> (clk_q != $past(clk_q)));

  // R6: clock idles high once the transfer is complete
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    (oe_q && $past(oe_q) && !act_q) |-> clk_q);

  // R7: enable follows sampled chip select; lanes quiet when disabled
  assert_oe_R7: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(cs_act));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> (data_q == '0));
endmodule

// File: rtl/ssc_pin_arbiter.sv
module ssc_pin_arbiter
  import ssc_pkg::*;
(
  input  logic rd_oe,
  input  logic rd_clk,
  input  logic busy,
  output logic pin
);
  pin_src_e src;

  always_comb begin
    src = rd_oe ? SRC_RDCLK : SRC_STATUS;
    pin = (src == SRC_RDCLK) ? rd_clk : ~busy;
  end
endmodule

// File: rtl/ssc_status_clock_pin.sv
module ssc_status_clock_pin #(
  parameter int W           = 16,
  parameter int LANES       = 4,
  parameter int CONV_CYCLES = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cs_n,
  input  logic [W-1:0]     sample_in,
  output logic             status_clk,
  output logic [LANES-1:0] sdo_data,
  output logic             sdo_oe
);
  logic         busy;
  logic [W-1:0] result;
  logic         rd_clk;

  ssc_busy_model #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .conv_start(conv_start),
    .sample_in(sample_in), .busy(busy), .result(result)
  );

  ssc_ddr_readout #(.W(W), .LANES(LANES)) u_rd (
    .clk(clk), .rst(rst), .cs_act(~cs_n), .result(result),
    .rd_clk(rd_clk), .rd_data(sdo_data), .rd_oe(sdo_oe)
  );

  ssc_pin_arbiter u_arb (
    .rd_oe(sdo_oe), .rd_clk(rd_clk), .busy(busy), .pin(status_clk)
  );

  // R4: with the lanes disabled, the pin only falls because of a strobe
  assert_status_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!sdo_oe && !$past(sdo_oe) && $past(status_clk) && !status_clk)
      |-> $past(conv_start));
endmodule

// File: tb/tb_ssc_status_clock_pin.sv
`timescale 1ns/100ps
module tb_ssc_status_clock_pin;
  localparam int W = 16;
  localparam int LANES = 4;
  localparam int C = 60;
  localparam int NIB = W / LANES;

  typedef struct packed {
    logic             pin;
    logic [LANES-1:0] nib;
  } item_t;

  logic clk = 1'b0;
  logic rst, conv_start, cs_n;
  logic [W-1:0] sample_in;
  logic status_clk, sdo_oe;
  logic [LANES-1:0] sdo_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ssc_status_clock_pin #(.W(W), .LANES(LANES), .CONV_CYCLES(C)) dut (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cs_n(cs_n),
    .sample_in(sample_in), .status_clk(status_clk),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: push expected per-cycle items, then hold chip select
  task automatic read_word(input logic [W-1:0] word);
    @(negedge clk);
    for (int j = 0; j < NIB; j++) begin
      item_t it;
      it.pin = j[0];
      it.nib = word[W-1-j*LANES -: LANES];
      sb_q.push_back(it);
    end
    cs_n = 1'b0;
    repeat (NIB + 2) @(negedge clk);
    cs_n = 1'b1;
  endtask

  // monitor: compare transfer cycles against the scoreboard
  int oe_cnt = 0;
  always @(negedge clk) begin
    if (!rst && sdo_oe) begin
      if (oe_cnt < NIB) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected transfer cycle", oe_cnt, 0);
        end else begin
          item_t e;
          e = sb_q.pop_front();
          chk(status_clk == e.pin, "R5", "read clock level", int'(status_clk), int'(e.pin));
          chk(sdo_data == e.nib, "R8 R9", "lane nibble", int'(sdo_data), int'(e.nib));
        end
      end else begin
        chk(status_clk == 1'b1, "R6", "idle clock level", int'(status_clk), 1);
      end
      oe_cnt++;
    end else begin
      oe_cnt = 0;
    end
  end

  // strobe and follow the busy window; optionally re-strobe while busy
  task automatic run_conv(input bit restrobe);
    @(negedge clk);
    conv_start = 1'b1;
    for (int i = 0; i <= C + 1; i++) begin
      @(negedge clk);
      if (i == 0) conv_start = 1'b0;
      if (restrobe && i == 2) conv_start = 1'b1;
      if (restrobe && i == 3) conv_start = 1'b0;
      chk(status_clk == (i >= C), restrobe ? "R3" : "R2", "status level",
          int'(status_clk), int'(i >= C));
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  initial begin
    rst = 1'b1; conv_start = 1'b0; cs_n = 1'b1; sample_in = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(status_clk == 1'b1, "R1", "reset pin", int'(status_clk), 1);
    chk(sdo_oe == 1'b0, "R1", "reset oe", int'(sdo_oe), 0);
    chk(sdo_data == '0, "R1", "reset data", int'(sdo_data), 0);

    sample_in = 16'hA5C3;
    run_conv(1'b0);
    read_word(16'hA5C3);
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R7", "oe after release", int'(sdo_oe), 0);
    chk(sdo_data == '0, "R7", "lanes after release", int'(sdo_data), 0);

    sample_in = 16'h3C5A;
    run_conv(1'b1);
    repeat (5) @(negedge clk);
    chk(status_clk == 1'b1, "R3", "no extra conversion", int'(status_clk), 1);
    read_word(16'h3C5A);

    // read overlapping a running conversion, release while busy
    sample_in = 16'h0F1E;
    strobe();
    read_word(16'h3C5A);
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R7", "oe after release", int'(sdo_oe), 0);
    chk(status_clk == 1'b0, "R4", "busy shown after release", int'(status_clk), 0);
    for (int i = 0; i < 2 * C && status_clk == 1'b0; i++) @(negedge clk);
    chk(status_clk == 1'b1, "R4", "status high after end", int'(status_clk), 1);
    read_word(16'h0F1E);

    // transfer straddles end of conversion
    sample_in = 16'h7788;
    strobe();
    repeat (C - 4) @(negedge clk);
    read_word(16'h0F1E);
    repeat (4) @(negedge clk);
    chk(status_clk == 1'b1, "R2", "conversion finished", int'(status_clk), 1);
    read_word(16'h7788);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule